// File: doc/BRIEF.md
# DMA Channel Preemption Arbiter

This block decides which DMA channel owns the transfer engine. Each channel presents a request line, a fixed priority code and two attribute bits. The first attribute marks the channel as one that may be suspended. The second marks it as one that may never suspend another channel. When the engine is idle, the highest-priority requester is granted. After that, the grant normally changes only when the running channel signals that its minor loop is complete.

In fixed-priority mode, one level of preemption is allowed. A suspendable running channel gives way to a higher-priority requester that is allowed to preempt. The arbiter keeps the displaced channel in a single saved-context register. When the preemptor reports that its minor loop is complete, the saved channel is put back. A channel that has just been restored cannot be suspended again until it has finished one read/write sequence. A preempting channel can never be preempted itself.

A mode input switches the arbiter to round-robin, where no suspension takes place. The surrounding engine moves the data and handles the descriptors. It reports back with two single-cycle strobes: one at the end of each read/write sequence and one at minor-loop completion.

Top module: `dma_preempt_arb`

## Requirements
- R1: After reset the arbiter is idle: busy_o, preempting_o, susp_valid_o, suspend_o and resume_o are all 0.
- R2: In fixed mode, a cycle in which the arbiter is idle and at least one request is high makes busy_o 1 after the next clock edge. grant_ch_o then names the requester with the numerically largest priority code; a larger code means higher priority, and codes are unique.
- R3: A minor_done_i strobe while a channel runs, with no channel suspended, returns the arbiter to idle at the next edge. The following edge arbitrates afresh.
- R4: A running channel is suspended when all of these hold: the arbiter is in fixed mode and busy, it is not already preempting, and the running channel's suspend-enable bit is 1. There must also be a requester whose preempt-inhibit bit is 0 and whose priority exceeds the running channel's. At the next edge grant_ch_o moves to the highest such requester, preempting_o and susp_valid_o become 1, susp_ch_o holds the displaced channel, and suspend_o pulses for exactly one cycle.
- R5: A running channel whose suspend-enable bit is 0 is never suspended.
- R6: A requester whose preempt-inhibit bit is 1 never suspends another channel, whatever its priority and the running channel's suspend-enable bit.
- R7: While preempting_o is 1, grant_ch_o does not change until the preemptor's minor_done_i, even when a still higher-priority channel requests.
- R8: A minor_done_i strobe from the preempting channel restores the saved channel at the next edge. grant_ch_o becomes the saved channel, preempting_o and susp_valid_o fall, and resume_o pulses for one cycle.
- R9: A restored channel cannot be suspended before a rw_done_i strobe. The earliest suspension happens at the edge after the edge that sampled the strobe.
- R10: With rr_mode_i at 1, no suspension occurs. An idle arbiter grants the first requesting channel in ascending index order after the last granted one, wrapping at the top. After reset the search starts at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rr_mode_i | input | 1 | 1 selects round-robin arbitration (no preemption) |
| req_i | input | NUM_CH | Per-channel service request |
| prio_i | input | NUM_CH*PRIO_W | Packed priority codes, channel i at bits [i*PRIO_W +: PRIO_W] |
| ecp_i | input | NUM_CH | Per-channel suspend-enable (may be preempted) |
| dpa_i | input | NUM_CH | Per-channel preempt-inhibit (may not preempt) |
| rw_done_i | input | 1 | Strobe: running channel finished one read/write sequence |
| minor_done_i | input | 1 | Strobe: running channel finished its minor loop |
| busy_o | output | 1 | A channel is granted |
| grant_ch_o | output | CH_W | Index of the granted channel |
| preempting_o | output | 1 | Granted channel is a preemptor |
| susp_valid_o | output | 1 | Saved-context register holds a suspended channel |
| susp_ch_o | output | CH_W | Index of the suspended channel |
| suspend_o | output | 1 | One-cycle pulse on a suspension |
| resume_o | output | 1 | One-cycle pulse on a restore |

## Verification
The bound checker tests, on every cycle, the properties that every suspension must have. The victim must be suspendable, the new owner must have preempt ability and a higher priority code, and round-robin mode must show no suspension. It also checks that the grant holds still while preempting and that every resume returns exactly the saved channel. The bench's scenarios are needed for the behaviour that depends on history or choice. This covers which channel wins out of a request mask, the delay from the read/write strobe before a restored channel becomes preemptable again, the rotation order of round-robin, and the cases where a suspension should have happened but did not.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   localparam int ARB_MIN_CH = 4;
   localparam int ARB_MAX_CH = 16;

   typedef enum logic [1:0] {
      ARB_IDLE    = 2'd0,
      ARB_RUN     = 2'd1,
      ARB_PREEMPT = 2'd2
   } arb_state_e;

   typedef enum logic {
      MODE_FIXED = 1'b0,
      MODE_RR    = 1'b1
   } arb_mode_e;

endpackage

// File: rtl/dma_arb_prio_pick.sv
module dma_arb_prio_pick #(
   parameter int NUM_CH = 8,
   parameter int PRIO_W = 4,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0]        mask_i,
   input  logic [NUM_CH*PRIO_W-1:0] prio_i,
   output logic                     found_o,
   output logic [CH_W-1:0]          idx_o,
   output logic [PRIO_W-1:0]        prio_o
);

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      prio_o  = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (mask_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
            found_o = 1'b1;
            idx_o   = CH_W'(i);
            prio_o  = prio_i[i*PRIO_W +: PRIO_W];
         end
      end
   end

endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
   parameter int NUM_CH = 8,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] mask_i,
   input  logic [CH_W-1:0]   last_i,
   output logic              found_o,
   output logic [CH_W-1:0]   idx_o
);

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int off = 1; off <= NUM_CH; off++) begin
         int cand;
         cand = (int'(last_i) + off) % NUM_CH;
         if (!found_o && mask_i[cand]) begin
            found_o = 1'b1;
            idx_o   = CH_W'(cand);
         end
      end
   end

endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int PRIO_W = 4,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  arb_mode_e         mode_i,
   input  logic              fix_found_i,
   input  logic [CH_W-1:0]   fix_idx_i,
   input  logic              rr_found_i,
   input  logic [CH_W-1:0]   rr_idx_i,
   input  logic              pre_found_i,
   input  logic [CH_W-1:0]   pre_idx_i,
   input  logic [PRIO_W-1:0] pre_prio_i,
   input  logic [PRIO_W-1:0] run_prio_i,
   input  logic              run_ecp_i,
   input  logic              rw_done_i,
   input  logic              minor_done_i,
   output arb_state_e        state_o,
   output logic [CH_W-1:0]   run_ch_o,
   output logic [CH_W-1:0]   last_ch_o,
   output logic [CH_W-1:0]   saved_ch_o,
   output logic              suspend_o,
   output logic              resume_o
);

   arb_state_e      state_q;
   logic [CH_W-1:0] run_q;
   logic [CH_W-1:0] last_q;
   logic [CH_W-1:0] saved_q;
   logic            restored_q;
   logic            suspend_q;
   logic            resume_q;

   logic            may_preempt;
   logic            start_fixed;
   logic            start_rr;

   always_comb begin
      may_preempt = (mode_i == MODE_FIXED) && run_ecp_i && !restored_q
                    && pre_found_i && (pre_prio_i > run_prio_i);
      start_fixed = (mode_i == MODE_FIXED) && fix_found_i;
      start_rr    = (mode_i == MODE_RR) && rr_found_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ARB_IDLE;
         run_q      <= '0;
         last_q     <= CH_W'(NUM_CH - 1);
         saved_q    <= '0;
         restored_q <= 1'b0;
         suspend_q  <= 1'b0;
         resume_q   <= 1'b0;
      end else begin
         suspend_q <= 1'b0;
         resume_q  <= 1'b0;
         unique case (state_q)
            ARB_IDLE: begin
               restored_q <= 1'b0;
               if (start_rr) begin
                  run_q   <= rr_idx_i;
                  last_q  <= rr_idx_i;
                  state_q <= ARB_RUN;
               end else if (start_fixed) begin
                  run_q   <= fix_idx_i;
                  last_q  <= fix_idx_i;
                  state_q <= ARB_RUN;
               end
            end
            ARB_RUN: begin
               if (minor_done_i) begin
                  state_q    <= ARB_IDLE;
                  restored_q <= 1'b0;
               end else if (may_preempt) begin
                  saved_q    <= run_q;
                  run_q      <= pre_idx_i;
                  state_q    <= ARB_PREEMPT;
                  suspend_q  <= 1'b1;
                  restored_q <= 1'b0;
               end else if (rw_done_i) begin
                  restored_q <= 1'b0;
               end
            end
            ARB_PREEMPT: begin
               if (minor_done_i) begin
                  run_q      <= saved_q;
                  state_q    <= ARB_RUN;
                  restored_q <= 1'b1;
                  resume_q   <= 1'b1;
               end
            end
            default: state_q <= ARB_IDLE;
         endcase
      end
   end

   assign state_o    = state_q;
   assign run_ch_o   = run_q;
   assign last_ch_o  = last_q;
   assign saved_ch_o = saved_q;
   assign suspend_o  = suspend_q;
   assign resume_o   = resume_q;

endmodule

// File: rtl/dma_preempt_arb.sv
module dma_preempt_arb
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int PRIO_W = 4,
   parameter bit RR_EN  = 1'b1,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rr_mode_i,
   input  logic [NUM_CH-1:0]        req_i,
   input  logic [NUM_CH*PRIO_W-1:0] prio_i,
   input  logic [NUM_CH-1:0]        ecp_i,
   input  logic [NUM_CH-1:0]        dpa_i,
   input  logic                     rw_done_i,
   input  logic                     minor_done_i,
   output logic                     busy_o,
   output logic [CH_W-1:0]          grant_ch_o,
   output logic                     preempting_o,
   output logic                     susp_valid_o,
   output logic [CH_W-1:0]          susp_ch_o,
   output logic                     suspend_o,
   output logic                     resume_o
);

   if (NUM_CH < ARB_MIN_CH || NUM_CH > ARB_MAX_CH) begin : g_bad_ch
      $error("dma_preempt_arb: NUM_CH out of supported range");
   end
   if (PRIO_W < CH_W || PRIO_W > 8) begin : g_bad_prio
      $error("dma_preempt_arb: PRIO_W cannot hold unique codes");
   end

   arb_mode_e         mode;
   logic              fix_found;
   logic [CH_W-1:0]   fix_idx;
   logic [PRIO_W-1:0] fix_prio;
   logic              pre_found;
   logic [CH_W-1:0]   pre_idx;
   logic [PRIO_W-1:0] pre_prio;
   logic              rr_found;
   logic [CH_W-1:0]   rr_idx;
   logic [CH_W-1:0]   last_ch;
   logic [CH_W-1:0]   run_ch;
   logic [CH_W-1:0]   saved_ch;
   logic [PRIO_W-1:0] run_prio;
   logic              run_ecp;
   arb_state_e        state;

   dma_arb_prio_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_fix_pick (
      .mask_i  (req_i),
      .prio_i  (prio_i),
      .found_o (fix_found),
      .idx_o   (fix_idx),
      .prio_o  (fix_prio)
   );

   dma_arb_prio_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_pre_pick (
      .mask_i  (req_i & ~dpa_i),
      .prio_i  (prio_i),
      .found_o (pre_found),
      .idx_o   (pre_idx),
      .prio_o  (pre_prio)
   );

   if (RR_EN) begin : g_rr
      dma_arb_rr_pick #(.NUM_CH(NUM_CH)) u_rr_pick (
         .mask_i  (req_i),
         .last_i  (last_ch),
         .found_o (rr_found),
         .idx_o   (rr_idx)
      );
      assign mode = rr_mode_i ? MODE_RR : MODE_FIXED;
   end else begin : g_fixed_only
      assign rr_found = 1'b0;
      assign rr_idx   = '0;
      assign mode     = MODE_FIXED;
   end

   always_comb begin
      run_prio = '0;
      run_ecp  = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (run_ch == CH_W'(i)) begin
            run_prio = prio_i[i*PRIO_W +: PRIO_W];
            run_ecp  = ecp_i[i];
         end
      end
   end

   dma_arb_ctrl #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (mode),
      .fix_found_i  (fix_found),
      .fix_idx_i    (fix_idx),
      .rr_found_i   (rr_found),
      .rr_idx_i     (rr_idx),
      .pre_found_i  (pre_found),
      .pre_idx_i    (pre_idx),
      .pre_prio_i   (pre_prio),
      .run_prio_i   (run_prio),
      .run_ecp_i    (run_ecp),
      .rw_done_i    (rw_done_i),
      .minor_done_i (minor_done_i),
      .state_o      (state),
      .run_ch_o     (run_ch),
      .last_ch_o    (last_ch),
      .saved_ch_o   (saved_ch),
      .suspend_o    (suspend_o),
      .resume_o     (resume_o)
   );

   logic unused_prio;
   assign unused_prio = ^fix_prio;

   assign busy_o       = (state != ARB_IDLE);
   assign preempting_o = (state == ARB_PREEMPT);
   assign susp_valid_o = (state == ARB_PREEMPT);
   assign grant_ch_o   = run_ch;
   assign susp_ch_o    = saved_ch;

endmodule

// File: rtl/dma_preempt_arb_chk.sv
module dma_preempt_arb_chk #(
   parameter int NUM_CH = 8,
   parameter int PRIO_W = 4,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     rr_mode_i,
   input logic [NUM_CH*PRIO_W-1:0] prio_i,
   input logic [NUM_CH-1:0]        ecp_i,
   input logic [NUM_CH-1:0]        dpa_i,
   input logic [CH_W-1:0]          grant_ch_o,
   input logic                     preempting_o,
   input logic                     susp_valid_o,
   input logic [CH_W-1:0]          susp_ch_o,
   input logic                     suspend_o,
   input logic                     resume_o
);

   logic [NUM_CH*PRIO_W-1:0] prio_q;
   logic [NUM_CH-1:0]        ecp_q;
   logic [NUM_CH-1:0]        dpa_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
         ecp_q  <= '0;
         dpa_q  <= '0;
      end else begin
         prio_q <= prio_i;
         ecp_q  <= ecp_i;
         dpa_q  <= dpa_i;
      end
   end

   function automatic logic [PRIO_W-1:0] code_of(input logic [NUM_CH*PRIO_W-1:0] v,
                                                 input logic [CH_W-1:0] ch);
      logic [PRIO_W-1:0] r;
      r = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (ch == CH_W'(i)) r = v[i*PRIO_W +: PRIO_W];
      return r;
   endfunction

   AST_VICTIM_SUSPENDABLE: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_o |-> ecp_q[susp_ch_o]); // R5
   AST_PREEMPTOR_ABLE: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_o |-> !dpa_q[grant_ch_o]); // R6
   AST_PREEMPTOR_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_o |-> (code_of(prio_q, grant_ch_o) > code_of(prio_q, susp_ch_o))); // R4
   AST_SUSPEND_SETS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_o |-> (preempting_o && susp_valid_o)); // R4
   AST_NO_NESTING: assert property (@(posedge clk) disable iff (!rst_n)
      (preempting_o && $past(preempting_o)) |-> $stable(grant_ch_o)); // R7
   AST_RESUME_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> (grant_ch_o == $past(susp_ch_o) && !preempting_o && !susp_valid_o)); // R8
   AST_RR_NO_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rr_mode_i) |-> !suspend_o); // R10
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(suspend_o && resume_o)); // R4

endmodule

bind dma_preempt_arb dma_preempt_arb_chk #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rr_mode_i    (rr_mode_i),
   .prio_i       (prio_i),
   .ecp_i        (ecp_i),
   .dpa_i        (dpa_i),
   .grant_ch_o   (grant_ch_o),
   .preempting_o (preempting_o),
   .susp_valid_o (susp_valid_o),
   .susp_ch_o    (susp_ch_o),
   .suspend_o    (suspend_o),
   .resume_o     (resume_o)
);

// File: tb/dma_preempt_arb_bench.sv
module dma_preempt_arb_bench;

   localparam int N  = 8;
   localparam int PW = 4;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rr_mode = 1'b0;
   logic [N-1:0]  req = '0;
   logic [N*PW-1:0] prio = '0;
   logic [N-1:0]  ecp = '0;
   logic [N-1:0]  dpa = '0;
   logic          rw_done = 1'b0;
   logic          minor_done = 1'b0;
   logic          busy, preempting, susp_valid, suspend, resume;
   logic [CW-1:0] grant, susp_ch;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dma_preempt_arb #(.NUM_CH(N), .PRIO_W(PW), .RR_EN(1'b1)) u_dma_preempt_arb (
      .clk(clk), .rst_n(rst_n), .rr_mode_i(rr_mode), .req_i(req), .prio_i(prio),
      .ecp_i(ecp), .dpa_i(dpa), .rw_done_i(rw_done), .minor_done_i(minor_done),
      .busy_o(busy), .grant_ch_o(grant), .preempting_o(preempting),
      .susp_valid_o(susp_valid), .susp_ch_o(susp_ch), .suspend_o(suspend), .resume_o(resume)
   );

   function automatic int prio_of(input int ch);
      return (ch * 5 + 3) % N;
   endfunction

   function automatic int best_of(input logic [N-1:0] m);
      int b = -1;
      int bp = -1;
      for (int i = 0; i < N; i++)
         if (m[i] && prio_of(i) > bp) begin bp = prio_of(i); b = i; end
      return b;
   endfunction

   function automatic int rr_next(input int last, input logic [N-1:0] m);
      for (int off = 1; off <= N; off++)
         if (m[(last + off) % N]) return (last + off) % N;
      return -1;
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_minor(input logic [N-1:0] next_req);
      req = next_req;
      minor_done = 1'b1;
      tick();
      minor_done = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req = '0; ecp = '0; dpa = '0; rw_done = 1'b0; minor_done = 1'b0;
      repeat (2) tick();
      rst_n = 1'b1;
      tick();
   endtask

   initial begin
      for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'(prio_of(i));
      do_reset();
      // R1 reset state
      chk(!busy && !preempting && !susp_valid && !suspend && !resume, "R1 reset idle",
          {busy, preempting, susp_valid, suspend, resume}, 0);

      // R2 sweep of all request masks from idle
      for (int m = 1; m < (1 << N); m++) begin
         req = N'(m);
         tick();
         chk(busy && int'(grant) == best_of(N'(m)), "R2 idle pick", int'(grant), best_of(N'(m)));
         finish_minor('0);
         chk(!busy, "R3 back to idle", busy, 0);
      end

      // R4 R5 R6 pairwise sweep: running a, late requester b
      for (int a = 0; a < N; a++) begin
         for (int b = 0; b < N; b++) begin
            if (b == a) continue;
            for (int e = 0; e < 2; e++) begin
               for (int d = 0; d < 2; d++) begin
                  bit exp_pre;
                  ecp = '0; dpa = '0;
                  ecp[a] = e[0];
                  dpa[b] = d[0];
                  req = '0; req[a] = 1'b1;
                  tick();
                  chk(busy && int'(grant) == a, "R2 single grant", int'(grant), a);
                  req[b] = 1'b1;
                  tick();
                  exp_pre = e[0] && !d[0] && (prio_of(b) > prio_of(a));
                  if (exp_pre) begin
                     chk(int'(grant) == b && preempting && susp_valid && int'(susp_ch) == a && suspend,
                         "R4 suspend", int'(grant), b);
                     tick();
                     chk(!suspend && int'(grant) == b, "R4 pulse width", suspend, 0);
                     req = '0; req[a] = 1'b1;
                     finish_minor(req);
                     chk(int'(grant) == a && resume && !preempting && !susp_valid, "R8 restore",
                         int'(grant), a);
                     finish_minor('0);
                     chk(!busy, "R3 idle after restore", busy, 0);
                  end else begin
                     if (e == 0)
                        chk(int'(grant) == a && !preempting && !suspend, "R5 not suspendable", int'(grant), a);
                     else if (d == 1)
                        chk(int'(grant) == a && !preempting && !suspend, "R6 inhibit blocks", int'(grant), a);
                     else
                        chk(int'(grant) == a && !preempting && !suspend, "R4 lower prio no suspend", int'(grant), a);
                     req = '0; req[b] = 1'b1;
                     finish_minor(req);
                     chk(!busy, "R3 idle after minor", busy, 0);
                     tick();
                     chk(busy && int'(grant) == b, "R3 rearbitrate", int'(grant), b);
                     finish_minor('0);
                  end
               end
            end
         end
      end

      // R7 R9 nesting and restored window; prio: ch1=0, ch5=4, ch4=7
      ecp = '1; dpa = '0;
      req = '0; req[1] = 1'b1;
      tick();
      req[5] = 1'b1;
      tick();
      chk(int'(grant) == 5 && preempting && int'(susp_ch) == 1, "R4 first preempt", int'(grant), 5);
      req[4] = 1'b1;
      for (int k = 0; k < 3; k++) begin
         tick();
         chk(int'(grant) == 5 && preempting && int'(susp_ch) == 1, "R7 no nesting", int'(grant), 5);
      end
      req[5] = 1'b0;
      finish_minor(req);
      chk(int'(grant) == 1 && resume && !preempting, "R8 restore under pressure", int'(grant), 1);
      for (int k = 0; k < 3; k++) begin
         tick();
         chk(int'(grant) == 1 && !preempting, "R9 restored holds", int'(grant), 1);
      end
      rw_done = 1'b1;
      tick();
      rw_done = 1'b0;
      chk(int'(grant) == 1 && !preempting, "R9 strobe edge", int'(grant), 1);
      tick();
      chk(int'(grant) == 4 && preempting && int'(susp_ch) == 1 && suspend, "R9 preempt after strobe",
          int'(grant), 4);
      req[4] = 1'b0;
      finish_minor(req);
      chk(int'(grant) == 1 && resume, "R8 second restore", int'(grant), 1);
      finish_minor('0);
      chk(!busy, "R3 final idle", busy, 0);

      // R10 round-robin rotation with varying masks
      do_reset();
      rr_mode = 1'b1;
      ecp = '1; dpa = '0;
      begin
         int last = N - 1;
         for (int k = 0; k < 20; k++) begin
            logic [N-1:0] m;
            int exp;
            m = N'((k * 37 + 8'h91) & 8'hFF);
            if (k < 9) m = '1;
            if (m == '0) m = 8'h01;
            req = m;
            tick();
            exp = rr_next(last, m);
            chk(busy && int'(grant) == exp, "R10 rotation", int'(grant), exp);
            last = exp;
            req = '1;
            tick();
            chk(int'(grant) == exp && !preempting && !suspend, "R10 no suspend", int'(grant), exp);
            finish_minor('0);
            chk(!busy, "R10 idle between", busy, 0);
         end
      end
      rr_mode = 1'b0;

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule